// File: doc/BRIEF.md
# Host/Peer Mailbox Ring Registers

This block is the device side of a small 32-bit register window shared between a host and an embedded peer. It holds two rings of 32-bit slots. Host writes fill the host-to-peer ring and the peer drains it. The peer fills the peer-to-host ring and host reads drain it. Each direction publishes its occupancy as free-running 8-bit read and write pointers. Software finds the number of waiting slots by subtracting the pointers modulo 256, and the free space by subtracting that from the depth field.

The host control register carries an interrupt enable, a write-one-to-clear interrupt status and a self-clearing doorbell bit. It also carries a ready flag, a ring reset flag and a sticky overflow flag. A second status register mirrors the peer's view and is read-only to the host.

Ring reset works as a handshake. The host raises the reset flag together with the doorbell. It waits until the peer reports ready. It then drops reset and sets its own ready flag.

Top module: `mbox_ring_regs`

## Requirements
- R1: Host writes go to offset 0x0 (enqueue) and offset 0x4 (control). Host reads come from offsets 0x4, 0x8 (dequeue) and 0xC (peer status). A write to 0xC has no effect.
- R2: Both status words use the same layout: bit 0 interrupt enable, bit 1 interrupt status, bit 2 doorbell (reads 0), bit 3 ready, bit 4 ring reset, bit 5 overflow, bits 15:8 read pointer, bits 23:16 write pointer, bits 31:24 depth in slots. After reset the host word reads `{DEPTH,16'h0,8'h00}`.
- R3: Each host write to 0x0 stores one slot and advances the host-to-peer write pointer. The peer sees the slots in order on `peer_pop_data`, and `peer_pop` advances the read pointer. `peer_rx_count` equals the filled count.
- R4: `peer_push` stores one slot in the peer-to-host ring. A host read of 0x8 returns the oldest slot on `host_rdata` in the cycle after the read strobe, and advances that ring's read pointer.
- R5: The filled count is (write pointer − read pointer) modulo 256 and never exceeds DEPTH. It stays correct when the write pointer has wrapped past 255 and the read pointer has not.
- R6: A host write to a full ring is dropped, leaving the pointers unchanged, and sets overflow (bit 5). Writing 1 to bit 5 of the control register clears it.
- R7: A host read of 0x8 while the peer-to-host ring is empty returns 0 and leaves both pointers unchanged.
- R8: `peer_irq_req` sets interrupt status. Writing 1 to bit 1 clears it. `host_irq` is high exactly when status and enable are both set.
- R9: Writing 1 to bit 2 of the control register pulses `peer_doorbell` for one cycle, starting the cycle after the write.
- R10: While the reset flag is set, `peer_reset` is high, all four pointers read zero and window writes are discarded.
- R11: The ready flag is cleared while reset is set. It can be set only by a control write that has bit 4 at 0.
- R12: Bit 3 of the peer status word follows the `peer_ready` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Byte offset of the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after `host_rd` |
| host_irq | output | 1 | Interrupt to the host |
| peer_doorbell | output | 1 | One-cycle doorbell pulse to the peer |
| peer_reset | output | 1 | Ring reset request seen by the peer |
| peer_ready | input | 1 | Peer reports ready |
| peer_irq_req | input | 1 | Peer request to raise the host interrupt |
| peer_push | input | 1 | Peer enqueues one slot toward the host |
| peer_push_data | input | 32 | Slot pushed by the peer |
| peer_pop | input | 1 | Peer dequeues one slot from the host |
| peer_pop_data | output | 32 | Oldest host-to-peer slot |
| peer_rx_count | output | 8 | Filled host-to-peer slots |

## Verification
A write, push, pop, interrupt request or control update changes the internal state at the clock edge on which the strobe is sampled. Its effect is therefore visible on the status words, `peer_rx_count`, `host_irq`, `peer_doorbell` and `peer_reset` one edge later. Read data shows the same one-edge lag: `host_rdata` carries the value captured at the edge that sampled `host_rd`. The bench drives every strobe at a falling edge for exactly one rising edge. It compares at the following falling edge, which is the first point where the registered result is due. For the doorbell, it samples a second falling edge to confirm that the pulse has already gone.

// File: rtl/mbox_ring_regs.sv
module mbox_ring_regs #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_irq,
  output logic        peer_doorbell,
  output logic        peer_reset,
  input  logic        peer_ready,
  input  logic        peer_irq_req,
  input  logic        peer_push,
  input  logic [31:0] peer_push_data,
  input  logic        peer_pop,
  output logic [31:0] peer_pop_data,
  output logic [7:0]  peer_rx_count
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  initial if (DEPTH < 2 || DEPTH > 128 || (1 << IW) != DEPTH)
    $display("mbox_ring_regs: DEPTH must be a power of two in 2..128");

  logic [31:0] h2p_mem [DEPTH];
  logic [31:0] p2h_mem [DEPTH];
  logic [7:0]  h2p_wp, h2p_rp, p2h_wp, p2h_rp;
  logic        ie, is_f, ready_f, rst_f, ovf_f, db_q;

  wire [7:0] h2p_fill = h2p_wp - h2p_rp;
  wire [7:0] p2h_fill = p2h_wp - p2h_rp;

  wire w_slot = host_wr && host_addr == 4'h0;
  wire w_csr  = host_wr && host_addr == 4'h4;
  wire r_slot = host_rd && host_addr == 4'h8;

  wire h2p_full = h2p_fill == DEPTH8;
  wire h2p_push = w_slot && !h2p_full && !rst_f;
  wire h2p_pop  = peer_pop && h2p_fill != 8'd0 && !rst_f;
  wire p2h_push = peer_push && p2h_fill != DEPTH8 && !rst_f;
  wire p2h_pop  = r_slot && p2h_fill != 8'd0 && !rst_f;

  wire [31:0] host_csr = {DEPTH8, h2p_wp, h2p_rp, 2'b00, ovf_f, rst_f, ready_f, 1'b0, is_f, ie};
  wire [31:0] peer_csr = {DEPTH8, p2h_wp, p2h_rp, 4'b0000, peer_ready, 3'b000};

  assign host_irq      = is_f & ie;
  assign peer_doorbell = db_q;
  assign peer_reset    = rst_f;
  assign peer_pop_data = h2p_mem[h2p_rp[IW-1:0]];
  assign peer_rx_count = h2p_fill;

  always_ff @(posedge clk) begin
    if (h2p_push) h2p_mem[h2p_wp[IW-1:0]] <= host_wdata;
    if (p2h_push) p2h_mem[p2h_wp[IW-1:0]] <= peer_push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h2p_wp <= '0; h2p_rp <= '0; p2h_wp <= '0; p2h_rp <= '0;
    end else if (rst_f) begin
      h2p_wp <= '0; h2p_rp <= '0; p2h_wp <= '0; p2h_rp <= '0;
    end else begin
      if (h2p_push) h2p_wp <= h2p_wp + 8'd1;
      if (h2p_pop)  h2p_rp <= h2p_rp + 8'd1;
      if (p2h_push) p2h_wp <= p2h_wp + 8'd1;
      if (p2h_pop)  p2h_rp <= p2h_rp + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; is_f <= 1'b0; ready_f <= 1'b0; rst_f <= 1'b0;
      ovf_f <= 1'b0; db_q <= 1'b0;
    end else begin
      db_q <= w_csr && host_wdata[2];
      if (w_csr) begin
        ie      <= host_wdata[0];
        rst_f   <= host_wdata[4];
        ready_f <= host_wdata[3] && !host_wdata[4];
      end else if (rst_f) begin
        ready_f <= 1'b0;
      end
      if (peer_irq_req) is_f <= 1'b1;
      else if (w_csr && host_wdata[1]) is_f <= 1'b0;
      if (w_slot && h2p_full && !rst_f) ovf_f <= 1'b1;
      else if (w_csr && host_wdata[5]) ovf_f <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) begin
      case (host_addr)
        4'h4:    host_rdata <= host_csr;
        4'h8:    host_rdata <= p2h_pop ? p2h_mem[p2h_rp[IW-1:0]] : 32'h0;
        4'hC:    host_rdata <= peer_csr;
        default: host_rdata <= 32'h0;
      endcase
    end
  end

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h2p_fill <= DEPTH8 && p2h_fill <= DEPTH8);

  assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_slot && h2p_full && !rst_f) |=> ($stable(h2p_wp) && ovf_f));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (r_slot && p2h_fill == 8'd0 && !rst_f) |=> ($stable(p2h_rp) && host_rdata == 32'h0));

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_irq_req && ie && !w_csr) |=> host_irq);

  assert_doorbell_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    peer_doorbell |-> $past(w_csr && host_wdata[2]));

  assert_reset_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_f |=> (h2p_wp == 8'd0 && h2p_rp == 8'd0 && p2h_wp == 8'd0 && p2h_rp == 8'd0));

  assert_ready_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_f && !w_csr) |=> !ready_f);
endmodule

// File: tb/mbox_ring_regs_test.sv
`timescale 1ns/1ps
module mbox_ring_regs_test;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [3:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic host_irq, peer_doorbell, peer_reset;
  logic peer_ready = 0, peer_irq_req = 0, peer_push = 0, peer_pop = 0;
  logic [31:0] peer_push_data = 0;
  logic [31:0] peer_pop_data;
  logic [7:0] peer_rx_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_ring_regs #(.DEPTH(8)) uut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0;
    check(host_rdata, exp, req);
  endtask

  task automatic pop(input logic [31:0] exp, input string req);
    @(negedge clk); check(peer_pop_data, exp, req); peer_pop = 1;
    @(negedge clk); peer_pop = 0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk); peer_push = 1; peer_push_data = d;
    @(negedge clk); peer_push = 0;
  endtask

  task automatic irq_pulse();
    @(negedge clk); peer_irq_req = 1;
    @(negedge clk); peer_irq_req = 0;
  endtask

  // op: 0 host write, 1 host read compare, 2 peer pop compare, 3 peer push
  localparam int NV = 18;
  localparam logic [69:0] VEC [NV] = '{
    {2'd1, 4'h4, 32'h0, 32'h0800_0000},          // R2 reset value of host word
    {2'd1, 4'hC, 32'h0, 32'h0800_0000},          // R12 peer not ready
    {2'd0, 4'h0, 32'hCAFE_0001, 32'h0},
    {2'd0, 4'h0, 32'hCAFE_0002, 32'h0},
    {2'd1, 4'h4, 32'h0, 32'h0802_0000},          // R3 write pointer 2
    {2'd2, 4'h0, 32'h0, 32'hCAFE_0001},          // R3 order
    {2'd1, 4'h4, 32'h0, 32'h0802_0100},
    {2'd2, 4'h0, 32'h0, 32'hCAFE_0002},
    {2'd3, 4'h0, 32'hBEEF_0001, 32'h0},
    {2'd1, 4'hC, 32'h0, 32'h0801_0000},          // R4 peer ring pointers
    {2'd1, 4'h8, 32'h0, 32'hBEEF_0001},          // R4 dequeue
    {2'd1, 4'hC, 32'h0, 32'h0801_0100},
    {2'd1, 4'h8, 32'h0, 32'h0},                  // R7 empty read gives 0
    {2'd1, 4'hC, 32'h0, 32'h0801_0100},          // R7 pointers unchanged
    {2'd0, 4'hC, 32'hFFFF_FFFF, 32'h0},
    {2'd1, 4'hC, 32'h0, 32'h0801_0100},          // R1 peer word read-only
    {2'd0, 4'h4, 32'h0000_0001, 32'h0},
    {2'd1, 4'h4, 32'h0, 32'h0802_0201}           // R2 layout with enable
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check({31'd0, host_irq}, 0, "R8 reset irq low");
    check({24'd0, peer_rx_count}, 0, "R3 reset count");

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [3:0] a; logic [31:0] d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        2'd0: wr(a, d);
        2'd1: rd(a, e, $sformatf("R1 R2 R3 R4 R7 R12 vector %0d", i));
        2'd2: pop(e, $sformatf("R3 vector %0d", i));
        default: push(d);
      endcase
    end

    // R6 overflow: ring holds 8, the ninth write is dropped
    for (int i = 0; i < 9; i++) wr(4'h0, 32'h100 + i);
    check({24'd0, peer_rx_count}, 8, "R6 count at full");
    rd(4'h4, 32'h080A_0221, "R6 overflow flag and pointers");
    for (int i = 0; i < 8; i++) pop(32'h100 + i, "R6 kept slots");
    wr(4'h4, 32'h21);
    rd(4'h4, 32'h080A_0A01, "R6 overflow cleared");

    // R5 wrap of the write pointer past 255
    for (int i = 0; i < 242; i++) begin wr(4'h0, i); pop(i, "R5 stream"); end
    for (int i = 0; i < 6; i++) wr(4'h0, 32'h200 + i);
    check({24'd0, peer_rx_count}, 6, "R5 count across wrap");
    rd(4'h4, 32'h0802_FC01, "R5 pointers across wrap");
    for (int i = 0; i < 6; i++) pop(32'h200 + i, "R5 wrapped data");

    // R8 interrupt
    irq_pulse();
    check({31'd0, host_irq}, 1, "R8 irq raised");
    rd(4'h4, 32'h0802_0203, "R8 status set");
    wr(4'h4, 32'h3);
    check({31'd0, host_irq}, 0, "R8 irq cleared");
    wr(4'h4, 32'h0);
    irq_pulse();
    check({31'd0, host_irq}, 0, "R8 masked");
    rd(4'h4, 32'h0802_0202, "R8 status while masked");
    wr(4'h4, 32'h2);

    // R9 doorbell
    wr(4'h4, 32'h4);
    check({31'd0, peer_doorbell}, 1, "R9 pulse");
    @(negedge clk);
    check({31'd0, peer_doorbell}, 0, "R9 single cycle");
    rd(4'h4, 32'h0802_0200, "R9 bit reads zero");

    // R10 R11 reset handshake
    wr(4'h0, 32'h55);
    push(32'h66);
    wr(4'h4, 32'h14);
    check({31'd0, peer_reset}, 1, "R10 reset seen by peer");
    check({31'd0, peer_doorbell}, 1, "R9 doorbell with reset");
    rd(4'h4, 32'h0800_0010, "R10 pointers cleared");
    rd(4'hC, 32'h0800_0000, "R10 peer pointers cleared");
    wr(4'h0, 32'h77);
    check({24'd0, peer_rx_count}, 0, "R10 write discarded");
    wr(4'h4, 32'h18);
    rd(4'h4, 32'h0800_0010, "R11 ready blocked in reset");
    peer_ready = 1;
    rd(4'hC, 32'h0800_0008, "R12 peer ready");
    wr(4'h4, 32'h0C);
    check({31'd0, peer_reset}, 0, "R10 reset released");
    rd(4'h4, 32'h0800_0008, "R11 ready set");
    wr(4'h0, 32'h88);
    pop(32'h88, "R3 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule